// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor read and write a bank of up to 64 byte-wide registers over a four-wire synchronous serial link: a serial clock, an active-low select, a data line into the block and a data line out of it. Each select frame carries exactly one command byte and then exactly one data byte. The command byte holds a read/write flag, a six-bit register address and one spare bit that the block ignores. A static mode input chooses whether bits travel least significant first or most significant first. The two orders mirror each other.

The serial pins are brought into the block's own clock domain through synchronizers. Edges on them are detected there, so the serial clock must be several times slower than the system clock. On a write, the block emits a single write strobe with the address and data once the last data bit has been captured. On a read, it emits a single read strobe when the command byte is complete. It takes the returned byte one cycle later by default and shifts it out on the falling serial clock edges of the data byte. It drives an output-enable to the pad only while those read bits are on the line.

Top module: `serport_slave`

## Requirements
- R1: After reset, and with the select held high, `sdo_oe` is 0 and neither `reg_wr_en` nor `reg_rd_en` pulses.
- R2: The command byte, named by its bit positions, carries the read/write flag in bit 0 (1 = read, 0 = write), the register address in bits 6..1 and a spare bit 7. The value of bit 7 has no effect on any transfer.
- R3: With `lsb_first` = 1, the line carries command bits 0,1,...,7 (flag, A0..A5, spare) and then data bits D0..D7.
- R4: With `lsb_first` = 0, the line carries command bits 7,6,...,0 (spare, A5..A0, flag) and then data bits D7..D0.
- R5: A write frame produces exactly one `reg_wr_en` pulse after the sixteenth bit. `reg_addr` and `reg_wr_data` carry the frame's address and data during that pulse.
- R6: A read frame produces exactly one `reg_rd_en` pulse, with `reg_addr` set, after the eighth bit. The returned byte appears on `sdo` starting with the falling serial clock edge that follows, in the bit order of the selected mode.
- R7: `sdo_oe` is 1 only while the eight data bits of a read are being shifted out. It is 0 during the command byte, during any write, and after the data byte.
- R8: If the select rises before the sixteenth bit of a write frame, no write strobe is issued and the register keeps its value.
- R9: Serial clock edges beyond the sixteenth in one frame issue no further strobe and do not turn the output back on.
- R10: A new command byte is taken only after the select goes high and then low again. While the select is high, the bit count and shift state are cleared.
- R11: The block samples `sdi` on rising serial clock edges and changes `sdo` only on falling serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low frame select from the host |
| sdi | input | 1 | Serial data from the host |
| lsb_first | input | 1 | Bit order: 1 = least significant first, 0 = most significant first; hold steady during a frame |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| reg_addr | output | ADDR_W | Register address of the current frame |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_data | output | DATA_W | Write data, valid with `reg_wr_en` |
| reg_rd_en | output | 1 | Single-cycle register read strobe |
| reg_rd_data | input | DATA_W | Register read data, READ_LAT cycles after `reg_rd_en` |

## Verification
A bit counter that is off by one would show up in the captured register data or the address on the first write, and as a shifted byte on `sdo` on the first read. A counter that is not cleared by the select would issue a strobe one frame too early or too late, and would show in the strobe count at once. Because the transmit shifter is armed only by the read fetch, a missed clear of that shifter would leave `sdo_oe` high after the data byte, and this is visible at the very next falling serial clock edge. Each frame in both bit orders is checked for its strobe count, strobe contents, returned byte and enable window.

// File: rtl/serport_pkg.sv
`timescale 1ns/1ps
package serport_pkg;

   // position of the receive counter within a frame
   typedef enum logic [1:0] {
      FR_CMD  = 2'd0,
      FR_DATA = 2'd1,
      FR_DONE = 2'd2
   } frame_ph_e;

   // read/write flag encoding in command bit 0
   localparam logic RW_READ  = 1'b1;
   localparam logic RW_WRITE = 1'b0;

endpackage

// File: rtl/serport_sync.sv
`timescale 1ns/1ps
module serport_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   if (STAGES < 1) begin : g_bad_stages
      $error("serport_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) d_out <= RST_VAL;
         else        d_out <= d_in;
      end
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
         end else begin
            st[0] <= d_in;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign d_out = st[STAGES-1];
   end

endmodule

// File: rtl/serport_rx.sv
`timescale 1ns/1ps
module serport_rx
   import serport_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              sclk_rise,
   input  logic              sdi_s,
   input  logic              lsb_first,
   output logic              cmd_pulse,
   output logic              cmd_rd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_pulse,
   output logic [DATA_W-1:0] wr_data,
   output frame_ph_e         phase
);

   localparam int CMD_W = ADDR_W + 2;
   localparam int FRAME = CMD_W + DATA_W;
   localparam int CNT_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(CMD_W);
   localparam logic [CNT_W-1:0] FR_LAST  = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] FR_END   = CNT_W'(FRAME);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("serport_rx: ADDR_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("serport_rx: DATA_W must be at least 2");
   end

   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-1:0]  cmd_sr;
   logic [DATA_W-1:0] dat_sr;
   logic              take;

   // edges past the end of the frame are dropped until the select cycles
   assign take = sclk_rise && (cnt != FR_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cmd_sr    <= '0;
         dat_sr    <= '0;
         cmd_pulse <= 1'b0;
         wr_pulse  <= 1'b0;
      end else if (cs_hi) begin
         cnt       <= '0;
         cmd_sr    <= '0;
         dat_sr    <= '0;
         cmd_pulse <= 1'b0;
         wr_pulse  <= 1'b0;
      end else begin
         cmd_pulse <= 1'b0;
         wr_pulse  <= 1'b0;
         if (take) begin
            cnt <= cnt + 1'b1;
            if (cnt < CMD_END) begin
               cmd_sr <= lsb_first ? {sdi_s, cmd_sr[CMD_W-1:1]}
                                   : {cmd_sr[CMD_W-2:0], sdi_s};
            end else begin
               dat_sr <= lsb_first ? {sdi_s, dat_sr[DATA_W-1:1]}
                                   : {dat_sr[DATA_W-2:0], sdi_s};
            end
            cmd_pulse <= (cnt == CMD_LAST);
            wr_pulse  <= (cnt == FR_LAST) && (cmd_sr[0] == RW_WRITE);
         end
      end
   end

   assign cmd_rd   = (cmd_sr[0] == RW_READ);
   assign cmd_addr = cmd_sr[ADDR_W:1];
   assign wr_data  = dat_sr;

   always_comb begin
      if (cnt < CMD_END)     phase = FR_CMD;
      else if (cnt < FR_END) phase = FR_DATA;
      else                   phase = FR_DONE;
   end

endmodule

// File: rtl/serport_tx.sv
`timescale 1ns/1ps
module serport_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              sclk_fall,
   input  logic              lsb_first,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int LEFT_W = $clog2(DATA_W + 1);
   localparam logic [LEFT_W-1:0] FULL = LEFT_W'(DATA_W);

   logic [DATA_W-1:0] sr;
   logic [LEFT_W-1:0] left;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         left   <= '0;
         armed  <= 1'b0;
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (cs_hi) begin
         sr     <= '0;
         left   <= '0;
         armed  <= 1'b0;
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (load) begin
         sr    <= load_data;
         left  <= FULL;
         armed <= 1'b1;
      end else if (sclk_fall && armed) begin
         if (left != '0) begin
            sdo    <= lsb_first ? sr[0] : sr[DATA_W-1];
            sr     <= lsb_first ? {1'b0, sr[DATA_W-1:1]} : {sr[DATA_W-2:0], 1'b0};
            left   <= left - 1'b1;
            sdo_oe <= 1'b1;
         end else begin
            // falling edge after the last data bit: release the line
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            armed  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/serport_slave.sv
`timescale 1ns/1ps
module serport_slave
   import serport_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int READ_LAT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              lsb_first,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rd_data
);

   if (READ_LAT < 0 || READ_LAT > 1) begin : g_bad_lat
      $error("serport_slave: READ_LAT must be 0 or 1");
   end

   // synchronized pins: {sclk, cs_n, sdi}; select resets to inactive
   logic [2:0] pins_s;
   logic       sclk_s;
   logic       cs_hi;
   logic       sdi_s;
   logic       sclk_q;
   logic       sclk_rise;
   logic       sclk_fall;

   serport_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({sclk, cs_n, sdi}),
      .d_out (pins_s)
   );

   assign sclk_s = pins_s[2];
   assign cs_hi  = pins_s[1];
   assign sdi_s  = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign sclk_rise =  sclk_s && !sclk_q;
   assign sclk_fall = !sclk_s &&  sclk_q;

   logic              cmd_pulse;
   logic              cmd_rd;
   logic [ADDR_W-1:0] cmd_addr;
   logic              wr_pulse;
   logic [DATA_W-1:0] wr_data;
   frame_ph_e         phase;

   serport_rx #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_hi     (cs_hi),
      .sclk_rise (sclk_rise),
      .sdi_s     (sdi_s),
      .lsb_first (lsb_first),
      .cmd_pulse (cmd_pulse),
      .cmd_rd    (cmd_rd),
      .cmd_addr  (cmd_addr),
      .wr_pulse  (wr_pulse),
      .wr_data   (wr_data),
      .phase     (phase)
   );

   assign reg_addr    = cmd_addr;
   assign reg_rd_en   = cmd_pulse && cmd_rd;
   assign reg_wr_en   = wr_pulse;
   assign reg_wr_data = wr_data;

   // read return path: the register file answers in READ_LAT cycles
   logic tx_load;

   if (READ_LAT == 0) begin : g_lat0
      assign tx_load = reg_rd_en;
   end else begin : g_lat1
      logic rd_pend;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_pend <= 1'b0;
         else if (cs_hi) rd_pend <= 1'b0;
         else            rd_pend <= reg_rd_en;
      end
      assign tx_load = rd_pend;
   end

   serport_tx #(
      .DATA_W (DATA_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_hi     (cs_hi),
      .sclk_fall (sclk_fall),
      .lsb_first (lsb_first),
      .load      (tx_load),
      .load_data (reg_rd_data),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe)
   );

endmodule

// File: rtl/serport_chk.sv
`timescale 1ns/1ps
module serport_chk
   import serport_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      cs_hi,
   input logic      sclk_fall,
   input logic      sdo,
   input logic      sdo_oe,
   input logic      wr_en,
   input logic      rd_en,
   input frame_ph_e phase
);

   // one write strobe per frame
   assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // write strobe only once the whole frame is in
   assert_write_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (phase == FR_DONE));

   // one read strobe, issued while the data byte is pending
   assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   assert_read_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (phase == FR_DATA));

   // a frame is either a read or a write, never both
   assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

   // a write never drives the line
   assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !sdo_oe);

   // deselect clears strobes and releases the line
   assert_deselect_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (!sdo_oe && !wr_en && !rd_en));

   // read data only changes on a falling serial clock edge
   assert_drive_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && !sclk_fall && !cs_hi) |=> $stable(sdo));

endmodule

bind serport_slave serport_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_hi     (cs_hi),
   .sclk_fall (sclk_fall),
   .sdo       (sdo),
   .sdo_oe    (sdo_oe),
   .wr_en     (reg_wr_en),
   .rd_en     (reg_rd_en),
   .phase     (phase)
);

// File: tb/tb_serport_slave.sv
`timescale 1ns/1ps
module tb_serport_slave;

   localparam int HALF = 64;   // serial half period, 8 system clocks

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sclk;
   logic       cs_n;
   logic       sdi;
   logic       lsb_first;
   logic       sdo;
   logic       sdo_oe;
   logic [5:0] reg_addr;
   logic       reg_wr_en;
   logic [7:0] reg_wr_data;
   logic       reg_rd_en;
   logic [7:0] reg_rd_data;

   always #4 clk = ~clk;   // 125 MHz

   serport_slave dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk        (sclk),
      .cs_n        (cs_n),
      .sdi         (sdi),
      .lsb_first   (lsb_first),
      .sdo         (sdo),
      .sdo_oe      (sdo_oe),
      .reg_addr    (reg_addr),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_en   (reg_rd_en),
      .reg_rd_data (reg_rd_data)
   );

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 37 + 5) & 8'hFF);
   endfunction

   // register bank model, one cycle read latency
   logic [7:0] mem [64];
   int         wr_count = 0;
   int         rd_count = 0;
   logic [5:0] last_wr_addr = '0;
   logic [7:0] last_wr_data = '0;
   logic [5:0] last_rd_addr = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
         reg_rd_data <= '0;
      end else begin
         if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            wr_count      <= wr_count + 1;
            last_wr_addr  <= reg_addr;
            last_wr_data  <= reg_wr_data;
         end
         if (reg_rd_en) begin
            reg_rd_data  <= mem[reg_addr];
            rd_count     <= rd_count + 1;
            last_rd_addr <= reg_addr;
         end
      end
   end

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_mem [64];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic frame_bit(input bit lsb, input logic [7:0] cmd,
                                      input logic [7:0] dat, input int k);
      if (k < 8)  return lsb ? cmd[k] : cmd[7-k];
      if (k < 16) return lsb ? dat[k-8] : dat[15-k];
      return 1'b0;
   endfunction

   // one select frame of nbits serial clocks; collects read bits and enable faults
   task automatic run_frame(input bit lsb, input logic [7:0] cmd, input logic [7:0] dat,
                            input int nbits, output logic [7:0] rx, output int oe_err,
                            output bit oe_early);
      bit rd;
      rd       = cmd[0];
      rx       = '0;
      oe_err   = 0;
      oe_early = 1'b0;
      lsb_first = lsb;
      #HALF;
      cs_n = 1'b0;
      #HALF;
      for (int k = 0; k < nbits; k++) begin
         sdi = frame_bit(lsb, cmd, dat, k);
         #HALF;
         if (rd && k >= 8 && k < 16) begin
            if (!sdo_oe) oe_err++;
            if (lsb) rx[k-8]  = sdo;
            else     rx[15-k] = sdo;
         end else if (sdo_oe) begin
            oe_err++;
         end
         sclk = 1'b1;
         #(HALF/2);
         if (k == 7) oe_early = sdo_oe;
         #(HALF/2);
         sclk = 1'b0;
      end
      #HALF;
      if (nbits < 8 || nbits > 15 || !rd) begin
         if (sdo_oe) oe_err++;
      end
      cs_n = 1'b1;
      #(4*HALF);
      if (sdo_oe) oe_err++;
   endtask

   // table: [16] lsb_first, [15] read flag, [14] spare bit, [13:8] address, [7:0] write data
   localparam logic [16:0] VEC [8] = '{
      {1'b1, 1'b0, 1'b0, 6'h05, 8'hB4},
      {1'b1, 1'b1, 1'b0, 6'h05, 8'h00},
      {1'b0, 1'b0, 1'b1, 6'h31, 8'h3A},
      {1'b0, 1'b1, 1'b0, 6'h31, 8'h00},
      {1'b1, 1'b1, 1'b1, 6'h31, 8'h00},
      {1'b0, 1'b0, 1'b0, 6'h00, 8'h61},
      {1'b1, 1'b1, 1'b0, 6'h00, 8'h00},
      {1'b0, 1'b1, 1'b1, 6'h12, 8'h00}
   };

   initial begin
      logic [7:0] rx;
      int         oe_err;
      bit         oe_early;
      int         prev_wr;
      int         prev_rd;

      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; lsb_first = 1'b1;
      for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
      #3;
      #80;
      check(sdo_oe == 1'b0, "R1 oe in reset", sdo_oe, 0);
      rst_n = 1'b1;
      #(8*HALF);
      check(sdo_oe == 1'b0, "R1 oe idle", sdo_oe, 0);
      check(wr_count == 0 && rd_count == 0, "R1 no strobes idle", wr_count + rd_count, 0);

      // table walk
      for (int v = 0; v < 8; v++) begin
         bit         lsb;
         bit         rd;
         logic [5:0] a;
         logic [7:0] d;
         lsb = VEC[v][16]; rd = VEC[v][15]; a = VEC[v][13:8]; d = VEC[v][7:0];
         prev_wr = wr_count; prev_rd = rd_count;
         run_frame(lsb, {VEC[v][14], a, rd}, d, 16, rx, oe_err, oe_early);
         if (!rd) begin
            check(wr_count == prev_wr + 1, "R5 one write strobe", wr_count - prev_wr, 1);
            check(last_wr_addr == a, "R2 write address", last_wr_addr, a);
            check(last_wr_data == d, lsb ? "R3 write data order" : "R4 write data order",
                  last_wr_data, d);
            exp_mem[a] = d;
         end else begin
            check(rd_count == prev_rd + 1 && last_rd_addr == a, "R6 read strobe and address",
                  last_rd_addr, a);
            check(rx == exp_mem[a], lsb ? "R3 read data order" : "R4 read data order",
                  rx, exp_mem[a]);
         end
         check(oe_err == 0, "R7 enable window", oe_err, 0);
      end

      // R8: truncated write leaves the register untouched
      prev_wr = wr_count;
      run_frame(1'b1, {1'b0, 6'h07, 1'b0}, 8'hF0, 12, rx, oe_err, oe_early);
      check(wr_count == prev_wr, "R8 no write on short frame", wr_count - prev_wr, 0);
      run_frame(1'b1, {1'b0, 6'h07, 1'b1}, 8'h00, 16, rx, oe_err, oe_early);
      check(rx == exp_mem[7], "R8 register unchanged", rx, exp_mem[7]);

      // R9: surplus clocks in a write frame and a read frame
      prev_wr = wr_count;
      run_frame(1'b0, {1'b0, 6'h09, 1'b0}, 8'h5E, 32, rx, oe_err, oe_early);
      check(wr_count == prev_wr + 1, "R9 single write with surplus clocks", wr_count - prev_wr, 1);
      check(last_wr_data == 8'h5E && last_wr_addr == 6'h09, "R9 write content", last_wr_data, 8'h5E);
      exp_mem[9] = 8'h5E;
      prev_rd = rd_count;
      run_frame(1'b0, {1'b0, 6'h09, 1'b1}, 8'h00, 24, rx, oe_err, oe_early);
      check(rd_count == prev_rd + 1, "R9 single read with surplus clocks", rd_count - prev_rd, 1);
      check(rx == 8'h5E, "R9 read data", rx, 8'h5E);
      check(oe_err == 0, "R9 line released after data byte", oe_err, 0);

      // R10: back-to-back frames each take their own command
      prev_wr = wr_count;
      run_frame(1'b1, {1'b1, 6'h3F, 1'b0}, 8'hC6, 16, rx, oe_err, oe_early);
      run_frame(1'b1, {1'b0, 6'h01, 1'b0}, 8'h2B, 16, rx, oe_err, oe_early);
      check(wr_count == prev_wr + 2, "R10 two frames two writes", wr_count - prev_wr, 2);
      check(last_wr_addr == 6'h01 && last_wr_data == 8'h2B, "R10 second command used",
            last_wr_addr, 1);
      exp_mem[63] = 8'hC6; exp_mem[1] = 8'h2B;

      // R11: output stays off after the eighth rising edge until the falling edge
      run_frame(1'b1, {1'b0, 6'h3F, 1'b1}, 8'h00, 16, rx, oe_err, oe_early);
      check(oe_early == 1'b0, "R11 no drive before falling edge", oe_early, 0);
      check(rx == 8'hC6 && oe_err == 0, "R11 read after falling edge", rx, 8'hC6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule